// File: doc/BRIEF.md
# Peripheral clock gating controller

This block manages power for a group of on-chip peripherals through one 16-bit control register on a simple register bus. Each peripheral has its own disable bit. A group-wide disable bit and a power-down input override all of them. From the register contents the block derives one clock enable per peripheral, which feeds an external gating cell. It also derives an output-hold signal, which tells a stopped peripheral to keep its pins frozen. It also drives a PLL power-down request and an oscillator-watchdog enable. A separate clock enable for a real-time-clock domain stays on in every mode, power-down included.

Every bus request passes through the block. The address is split into slots. Slot 0 is the control register, and slot `i+1` belongs to peripheral `i`. A request to a peripheral whose clock is stopped is refused: the peripheral sees no select, and the response carries zero data and an error flag for one cycle. The control register answers in every mode, so software can always bring peripherals back. Idle and slow-down operation need nothing special, because register access is never gated by them.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000. Every `per_clk_en` bit is 1, every `per_hold` bit is 0, `pll_pd_req` is 0, `osc_wdt_en` is 1 and `rtc_clk_en` is 1.
- R2: A write that sets peripheral bit `i` (bit `i`, for `i` < NUM_PERIPH) clears `per_clk_en[i]` from the cycle after the write. A later write that clears the bit restores the enable in the same way. Other peripherals are not affected.
- R3: While group bit 15 is 1, every `per_clk_en` bit is 0, whatever the peripheral bits hold.
- R4: While PLL bit 13 is 1, `pll_pd_req` is 1 and `osc_wdt_en` is 0. Peripheral enables are not affected.
- R5: `per_hold[i]` is 1 in exactly the cycles in which `per_clk_en[i]` is 0. It rises in the cycle the enable drops and falls in the cycle the enable returns.
- R6: A request to the slot of a peripheral whose enable is 0 drives no `per_sel` bit. It is answered one cycle later with `resp_err`=1 and `resp_rdata`=0, and `resp_err` is 0 again in the following cycle unless another refused request follows.
- R7: A request to the slot of an enabled peripheral asserts only that peripheral's `per_sel` bit in the same cycle, with `per_offs` equal to the low address bits. One cycle later it answers with that peripheral's `per_rdata` slice and `resp_err`=0.
- R8: The control register in slot 0 is readable and writable in every state, including group disable and power-down. Its accesses never raise `resp_err`.
- R9: Bits 12 and 14, and the peripheral bits at or above NUM_PERIPH, are reserved. They read as 0, and writing 1 to them has no effect.
- R10: While `pwr_down` is 1, every `per_clk_en` bit is 0 in the same cycle. `rtc_clk_en` stays 1 at all times after reset.
- R11: A request to a slot above NUM_PERIPH is refused like R6: no select, zero data and `resp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_down | input | 1 | Power-down mode; stops all peripheral clocks |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Address: slot in upper bits, offset in low SLOT_SHIFT bits |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_err | output | 1 | Request was refused |
| resp_rdata | output | 16 | Read data (0 when refused or on writes) |
| per_sel | output | NUM_PERIPH (12) | Per-peripheral select, gated by its clock enable |
| per_wr | output | 1 | Write flag forwarded to peripherals |
| per_offs | output | SLOT_SHIFT (4) | Register offset forwarded to peripherals |
| per_wdata | output | 16 | Write data forwarded to peripherals |
| per_rdata | input | 16*NUM_PERIPH | Read data of all peripherals, peripheral i in slice i |
| per_clk_en | output | NUM_PERIPH (12) | Clock enable per peripheral |
| per_hold | output | NUM_PERIPH (12) | Freeze output pins of a stopped peripheral |
| rtc_clk_en | output | 1 | Always-on real-time-clock enable |
| pll_pd_req | output | 1 | PLL power-down request |
| osc_wdt_en | output | 1 | Oscillator watchdog enable |

## Verification
Register effects appear one clock after the write edge. The bench drives at a falling edge, lets the next rising edge capture the write, and reads the enable, hold, PLL and watchdog outputs at the falling edge that follows. `per_sel` and the `pwr_down` effect are combinational, so they are sampled 1 ns after the driving falling edge, within the same cycle. Bus responses are registered once and are read one full cycle after the request. One further cycle is then checked to confirm that the error flag lasts exactly one cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int REG_W   = 16;
  localparam int PLL_BIT = 13;
  localparam int GRP_BIT = 15;

  typedef enum logic [1:0] {
    SLOT_CTRL   = 2'd0,
    SLOT_PERIPH = 2'd1,
    SLOT_NONE   = 2'd2
  } slot_kind_e;

  // Writable bits: the peripheral disables, the PLL bit and the group bit.
  function automatic logic [REG_W-1:0] write_mask(int n_periph);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < n_periph || i == PLL_BIT || i == GRP_BIT) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pcg_ctrl_reg.sv
module pcg_ctrl_reg
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q
);
  localparam logic [REG_W-1:0] WMASK = write_mask(NUM_PERIPH);

  logic [REG_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == ($past(wdata) & WMASK)));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~WMASK) == '0);
endmodule

// File: rtl/pcg_enable_gen.sv
module pcg_enable_gen #(
  parameter int NUM_PERIPH = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] per_dis,
  input  logic                  grp_dis,
  input  logic                  pll_dis,
  input  logic                  pwr_down,
  output logic [NUM_PERIPH-1:0] per_clk_en,
  output logic [NUM_PERIPH-1:0] per_hold,
  output logic                  pll_pd_req,
  output logic                  osc_wdt_en
);
  logic grp_stop;
  assign grp_stop = grp_dis | pwr_down;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_lane
    logic run;
    assign run           = ~(per_dis[i] | grp_stop);
    assign per_clk_en[i] = run;
    assign per_hold[i]   = ~run;
  end

  assign pll_pd_req = pll_dis;
  assign osc_wdt_en = ~pll_dis;

  // R3
  grp_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_dis |-> (per_clk_en == '0));

  // R10
  pd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (per_hold == '1));

  // R4
  pll_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pd_req |-> !osc_wdt_en);
endmodule

// File: rtl/pcg_access_filter.sv
module pcg_access_filter
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 12,
  parameter int ADDR_W     = 8,
  parameter int SLOT_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [NUM_PERIPH-1:0]       per_clk_en,
  input  logic [REG_W*NUM_PERIPH-1:0] per_rdata,
  input  logic [REG_W-1:0]            ctrl_q,
  output logic                        ctrl_wr_en,
  output logic [NUM_PERIPH-1:0]       per_sel,
  output logic                        resp_valid,
  output logic                        resp_err,
  output logic [REG_W-1:0]            resp_rdata
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

  logic [SLOT_W-1:0]     slot;
  slot_kind_e            kind;
  logic [NUM_PERIPH-1:0] hit;
  logic                  blocked;
  logic [REG_W-1:0]      rdata_d;
  logic                  resp_valid_q, resp_err_q;
  logic [REG_W-1:0]      resp_rdata_q;

  assign slot = req_addr[ADDR_W-1:SLOT_SHIFT];

  always_comb begin
    if (slot == '0)                             kind = SLOT_CTRL;
    else if (int'(slot) <= NUM_PERIPH)          kind = SLOT_PERIPH;
    else                                        kind = SLOT_NONE;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_dec
    assign hit[i]     = req_valid && (kind == SLOT_PERIPH) && (slot == SLOT_W'(i + 1));
    assign per_sel[i] = hit[i] & per_clk_en[i];
  end

  assign ctrl_wr_en = req_valid && (kind == SLOT_CTRL) && req_write;
  assign blocked    = req_valid && (kind != SLOT_CTRL) && (per_sel == '0);

  always_comb begin
    rdata_d = '0;
    if (req_valid && !req_write) begin
      if (kind == SLOT_CTRL) rdata_d = ctrl_q;
      for (int i = 0; i < NUM_PERIPH; i++) begin
        if (per_sel[i]) rdata_d = rdata_d | per_rdata[i*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_err_q   <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      resp_valid_q <= req_valid;
      resp_err_q   <= blocked;
      resp_rdata_q <= rdata_d;
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_err   = resp_err_q;
  assign resp_rdata = resp_rdata_q;

  // R6
  refused_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_valid && resp_rdata == '0));

  // R6
  sel_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel & ~per_clk_en) == '0);

  // R7
  sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_sel));

  // R8
  ctrl_never_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == SLOT_CTRL) |=> !resp_err);
endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 12,
  parameter int ADDR_W     = 8,
  parameter int SLOT_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        arst_n,
  input  logic                        pwr_down,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [15:0]                 req_wdata,
  output logic                        resp_valid,
  output logic                        resp_err,
  output logic [15:0]                 resp_rdata,
  output logic [NUM_PERIPH-1:0]       per_sel,
  output logic                        per_wr,
  output logic [SLOT_SHIFT-1:0]       per_offs,
  output logic [15:0]                 per_wdata,
  input  logic [16*NUM_PERIPH-1:0]    per_rdata,
  output logic [NUM_PERIPH-1:0]       per_clk_en,
  output logic [NUM_PERIPH-1:0]       per_hold,
  output logic                        rtc_clk_en,
  output logic                        pll_pd_req,
  output logic                        osc_wdt_en
);
  logic             rst_n;
  logic             ctrl_wr_en;
  logic [REG_W-1:0] ctrl_q;
  logic             rtc_q, rtc_d;

  pcg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pcg_ctrl_reg #(.NUM_PERIPH(NUM_PERIPH)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr_en),
    .wdata  (req_wdata),
    .ctrl_q (ctrl_q)
  );

  pcg_enable_gen #(.NUM_PERIPH(NUM_PERIPH)) u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_dis    (ctrl_q[NUM_PERIPH-1:0]),
    .grp_dis    (ctrl_q[GRP_BIT]),
    .pll_dis    (ctrl_q[PLL_BIT]),
    .pwr_down   (pwr_down),
    .per_clk_en (per_clk_en),
    .per_hold   (per_hold),
    .pll_pd_req (pll_pd_req),
    .osc_wdt_en (osc_wdt_en)
  );

  pcg_access_filter #(
    .NUM_PERIPH (NUM_PERIPH),
    .ADDR_W     (ADDR_W),
    .SLOT_SHIFT (SLOT_SHIFT)
  ) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .per_clk_en (per_clk_en),
    .per_rdata  (per_rdata),
    .ctrl_q     (ctrl_q),
    .ctrl_wr_en (ctrl_wr_en),
    .per_sel    (per_sel),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata)
  );

  assign per_wr    = req_write;
  assign per_offs  = req_addr[SLOT_SHIFT-1:0];
  assign per_wdata = req_wdata;

  // Always-on enable for the real-time-clock domain; only reset clears it.
  assign rtc_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtc_q <= 1'b0;
    else        rtc_q <= rtc_d;
  end

  assign rtc_clk_en = rtc_q;

  // R10
  rtc_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rtc_clk_en);

  // R5
  hold_tracks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hold ^ per_clk_en) == '1);
endmodule

// File: tb/pclk_gate_ctrl_test.sv
`timescale 1ns/1ps
module pclk_gate_ctrl_test;
  localparam int N  = 12;
  localparam int AW = 8;
  localparam int SS = 4;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [15:0] resp_rdata;
  logic [N-1:0] per_sel, per_clk_en, per_hold;
  logic per_wr;
  logic [SS-1:0] per_offs;
  logic [15:0] per_wdata;
  logic [16*N-1:0] per_rdata;
  logic rtc_clk_en, pll_pd_req, osc_wdt_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [N-1:0] sel_seen;
  logic [SS-1:0] offs_seen;
  logic [15:0] rd;
  logic er;

  always #2 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_rd
    assign per_rdata[i*16 +: 16] = 16'hC000 + 16'(i) * 16'h0101;
  end

  pclk_gate_ctrl #(.NUM_PERIPH(N), .ADDR_W(AW), .SLOT_SHIFT(SS)) uut (
    .clk(clk), .arst_n(arst_n), .pwr_down(pwr_down),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
    .resp_rdata(resp_rdata), .per_sel(per_sel), .per_wr(per_wr),
    .per_offs(per_offs), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_clk_en(per_clk_en), .per_hold(per_hold), .rtc_clk_en(rtc_clk_en),
    .pll_pd_req(pll_pd_req), .osc_wdt_en(osc_wdt_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus transfer; select snapshot in the request cycle, response one cycle later.
  task automatic bus(input bit wr, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    sel_seen = per_sel; offs_seen = per_offs;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = resp_rdata; er = resp_err;
  endtask

  task automatic t_reset();
    chk(per_clk_en == ALL, "R1 clk_en", 32'(per_clk_en), 32'(ALL));
    chk(per_hold == '0, "R1 hold", 32'(per_hold), 0);
    chk(pll_pd_req == 0 && osc_wdt_en == 1, "R1 pll/wdt",
        {pll_pd_req, osc_wdt_en}, 32'h1);
    chk(rtc_clk_en == 1, "R1 rtc", 32'(rtc_clk_en), 1);
    bus(0, 8'h00, 0);
    chk(rd == 16'h0000 && !er, "R1 ctrl reads zero", 32'(rd), 0);
  endtask

  task automatic t_periph_bit();
    bus(1, 8'h00, 16'h0008);
    chk(per_clk_en == (ALL & ~N'(8)), "R2 bit3 off", 32'(per_clk_en), 32'(ALL & ~N'(8)));
    chk(per_hold == N'(8), "R5 hold bit3", 32'(per_hold), 8);
    bus(1, 8'h00, 16'h0000);
    chk(per_clk_en == ALL, "R2 bit3 back on", 32'(per_clk_en), 32'(ALL));
    chk(per_hold == '0, "R5 hold released", 32'(per_hold), 0);
  endtask

  task automatic t_group();
    bus(1, 8'h00, 16'h8001);
    chk(per_clk_en == '0, "R3 group off", 32'(per_clk_en), 0);
    chk(per_hold == ALL, "R5 group hold", 32'(per_hold), 32'(ALL));
    bus(0, 8'h00, 0);
    chk(rd == 16'h8001 && !er, "R8 ctrl under group", 32'({er, rd}), 32'h8001);
    bus(1, 8'h00, 16'h0000);
  endtask

  task automatic t_pll();
    bus(1, 8'h00, 16'h2000);
    chk(pll_pd_req == 1 && osc_wdt_en == 0, "R4 pll off", {pll_pd_req, osc_wdt_en}, 32'h2);
    chk(per_clk_en == ALL, "R4 enables kept", 32'(per_clk_en), 32'(ALL));
    bus(1, 8'h00, 16'h0000);
    chk(pll_pd_req == 0 && osc_wdt_en == 1, "R4 pll back", {pll_pd_req, osc_wdt_en}, 32'h1);
  endtask

  task automatic t_blocked();
    bus(1, 8'h00, 16'h0004);
    bus(0, 8'h33, 0);
    chk(sel_seen == '0, "R6 no select", 32'(sel_seen), 0);
    chk(er == 1 && rd == 0, "R6 err and zero", 32'({er, rd}), 32'h10000);
    @(negedge clk);
    chk(resp_err == 0, "R6 err one cycle", 32'(resp_err), 0);
    bus(1, 8'h30, 16'h5555);
    chk(sel_seen == '0 && er == 1, "R6 write refused", 32'({er, sel_seen}), 32'h1000);
    bus(1, 8'h00, 16'h0000);
  endtask

  task automatic t_enabled();
    bus(0, 8'h65, 0);
    chk(sel_seen == N'(32) && offs_seen == 4'h5, "R7 select/offset",
        32'({offs_seen, sel_seen}), 32'h5020);
    chk(rd == 16'hC505 && !er, "R7 read data", 32'({er, rd}), 32'hC505);
  endtask

  task automatic t_reserved();
    bus(1, 8'h00, 16'hFFFF);
    bus(0, 8'h00, 0);
    chk(rd == 16'hAFFF, "R9 reserved read zero", 32'(rd), 32'hAFFF);
    bus(1, 8'h00, 16'h5000);
    bus(0, 8'h00, 0);
    chk(rd == 16'h0000, "R9 reserved write ignored", 32'(rd), 0);
  endtask

  task automatic t_powerdown();
    @(negedge clk);
    pwr_down = 1'b1;
    #1;
    chk(per_clk_en == '0 && per_hold == ALL, "R10 pd stops clocks", 32'(per_clk_en), 0);
    chk(rtc_clk_en == 1, "R10 rtc stays on", 32'(rtc_clk_en), 1);
    bus(1, 8'h00, 16'h0002);
    bus(0, 8'h00, 0);
    chk(rd == 16'h0002 && !er, "R8 ctrl in power-down", 32'({er, rd}), 32'h2);
    @(negedge clk);
    pwr_down = 1'b0;
    #1;
    chk(per_clk_en == (ALL & ~N'(2)), "R10 pd release", 32'(per_clk_en), 32'(ALL & ~N'(2)));
    bus(1, 8'h00, 16'h0000);
  endtask

  task automatic t_unmapped();
    bus(0, 8'hF0, 0);
    chk(sel_seen == '0 && er == 1 && rd == 0, "R11 unmapped slot",
        32'({er, sel_seen}), 32'h1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_periph_bit();
    t_group();
    t_pll();
    t_blocked();
    t_enabled();
    t_reserved();
    t_powerdown();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule